// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block holds the host-visible storage of a small character display controller: per-position character codes, a per-position flash mask, a pointer into user-defined glyph memory, and an 8-bit control word. Its job is the built-in self-test. The host writes a control word with the start bit set. The sequencer then runs a schedule of exactly `2**TEST_LOG2` clocks. The default is 262,144 clocks.

The schedule has three phases. In the first it fetches every entry of the character-decoder ROM, one address per clock, and adds the returned bytes into an 8-bit running sum. In the second it asks the display drive logic for a checkerboard pattern, and in the third for the inverse checkerboard. When the schedule ends, the block blanks the character storage, zeroes the flash mask, sets the glyph pointer to all ones and clears the control word. The only exception is the pass bit, which is set when the sum matched the `GOLDEN_SUM` parameter and cleared otherwise.

States: `ST_IDLE`, `ST_ROMSUM`, `ST_CHECKER`, `ST_INVERSE`.

Transitions:
- `ST_IDLE -> ST_ROMSUM` on an accepted start write.
- `ST_ROMSUM -> ST_CHECKER` after the last cycle of the first quarter.
- `ST_CHECKER -> ST_INVERSE` after a further three eighths.
- `ST_INVERSE -> ST_IDLE` on the final cycle. The end state is committed on that same edge.

Top module: `disp_selftest`

## Requirements
- R1: After reset, every character location reads 0x20, the flash mask, glyph pointer and control word read 0, `busy` is 0 and `pat_sel` is 0.
- R2: While idle, host writes update the addressed register. Addresses 0..N_CHARS-1 are characters, N_CHARS is the flash mask, N_CHARS+1 is the glyph pointer and N_CHARS+2 is the control word. Control bit 5 ignores writes.
- R3: An idle write to the control word with bit 6 = 1 raises `busy` on the next cycle. `busy` then stays high for exactly 2**TEST_LOG2 cycles, and bit 6 reads 1 throughout.
- R4: In busy cycle k, for k < 2**ROM_AW, `rom_addr` equals k. Busy cycle 0 is the first cycle with `busy` high.
- R5: `pat_sel` is 0 (normal) for the first quarter of the test. It is 1 (checker) for the next three eighths and 2 (inverse) for the last three eighths. It is 0 whenever `busy` is low.
- R6: At completion, control bit 5 becomes 1 only if the 8-bit modular sum of all ROM bytes equals `GOLDEN_SUM`; otherwise it becomes 0. It keeps that value until the next test ends.
- R7: At completion, all characters read 0x20, the flash mask reads 0, the glyph pointer reads all ones, and the control word reads 0 apart from bit 5. Bit 6 therefore clears itself.
- R8: Host writes while `busy` is high change no register and do not restart or extend the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HADR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| busy | output | 1 | High for the whole self-test |
| rom_addr | output | ROM_AW | Decoder ROM address |
| rom_data | input | 8 | Decoder ROM data, same cycle as address |
| pat_sel | output | 2 | Display pattern: 0 normal, 1 checker, 2 inverse |

## Verification
The hardest case to reach from the ports is a failing checksum, because a correct ROM always produces a pass. The bench's ROM model can flip one bit of the byte returned at a chosen address. That address is drawn at random or set to the first or last entry, so each run moves the sum by one step and must report a fail. Passing runs and failing runs are interleaved, so the pass bit is seen moving in both directions. Writes and a restart attempt are injected mid-test, and the affected register is read back while the test is still busy.

// File: rtl/dst_pkg.sv
package dst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ROMSUM   = 2'd1,
        ST_CHECKER  = 2'd2,
        ST_INVERSE  = 2'd3
    } dst_state_e;

    typedef enum logic [1:0] {
        PAT_NORMAL  = 2'd0,
        PAT_CHECKER = 2'd1,
        PAT_INVERSE = 2'd2
    } dst_pat_e;

    localparam int CW_PASS  = 5;
    localparam int CW_START = 6;
    localparam logic [7:0] BLANK_CODE = 8'h20;
endpackage

// File: rtl/dst_phase_timer.sv
module dst_phase_timer #(
    parameter int TEST_LOG2 = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 run,
    output logic [TEST_LOG2-1:0] cnt,
    output logic                 end_rom,
    output logic                 end_chk,
    output logic                 end_all
);
    localparam longint unsigned EIGHTH  = 64'd1 << (TEST_LOG2 - 3);
    localparam longint unsigned ROM_LEN = 2 * EIGHTH;
    localparam longint unsigned PAT_LEN = 3 * EIGHTH;
    localparam logic [TEST_LOG2-1:0] ROM_LAST = TEST_LOG2'(ROM_LEN - 1);
    localparam logic [TEST_LOG2-1:0] CHK_LAST = TEST_LOG2'(ROM_LEN + PAT_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign end_rom = (cnt == ROM_LAST);
    assign end_chk = (cnt == CHK_LAST);
    assign end_all = &cnt;
endmodule

// File: rtl/dst_checksum.sv
module dst_checksum #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (en) begin
            sum <= sum + data;
        end
    end
endmodule

// File: rtl/disp_selftest.sv
module disp_selftest
    import dst_pkg::*;
#(
    parameter int         TEST_LOG2  = 18,
    parameter int         ROM_AW     = 7,
    parameter int         N_CHARS    = 8,
    parameter int         UDC_AW     = 4,
    parameter int         HADR_W     = 4,
    parameter logic [7:0] GOLDEN_SUM = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HADR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              busy,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic [1:0]        pat_sel
);
    localparam int ROM_DEPTH = 1 << ROM_AW;
    localparam logic [HADR_W-1:0] FLASH_ADR = HADR_W'(N_CHARS);
    localparam logic [HADR_W-1:0] UDC_ADR   = HADR_W'(N_CHARS + 1);
    localparam logic [HADR_W-1:0] CTRL_ADR  = HADR_W'(N_CHARS + 2);
    localparam logic [TEST_LOG2-1:0] ROM_END = TEST_LOG2'(ROM_DEPTH);

    dst_state_e state_q, state_d;

    logic [N_CHARS-1:0][7:0] char_q;
    logic [N_CHARS-1:0]      flash_q;
    logic [UDC_AW-1:0]       udc_q;
    logic [7:0]              ctrl_q;

    logic [TEST_LOG2-1:0] cnt;
    logic end_rom, end_chk, end_all;
    logic [7:0] sum;
    logic start_hit, wr_ok, rom_en, finish;

    assign wr_ok     = host_we && (state_q == ST_IDLE);
    assign start_hit = wr_ok && (host_addr == CTRL_ADR) && host_wdata[CW_START];
    assign rom_en    = (state_q == ST_ROMSUM) && (cnt < ROM_END);
    assign finish    = (state_q == ST_INVERSE) && end_all;

    dst_phase_timer #(.TEST_LOG2(TEST_LOG2)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_hit),
        .run     (state_q != ST_IDLE),
        .cnt     (cnt),
        .end_rom (end_rom),
        .end_chk (end_chk),
        .end_all (end_all)
    );

    dst_checksum #(.DW(8)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_hit),
        .en    (rom_en),
        .data  (rom_data),
        .sum   (sum)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_hit) state_d = ST_ROMSUM;
            ST_ROMSUM:  if (end_rom)   state_d = ST_CHECKER;
            ST_CHECKER: if (end_chk)   state_d = ST_INVERSE;
            ST_INVERSE: if (end_all)   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        pat_sel  = PAT_NORMAL;
        rom_addr = rom_en ? cnt[ROM_AW-1:0] : '0;
        unique case (state_q)
            ST_IDLE:    busy    = 1'b0;
            ST_ROMSUM:  pat_sel = PAT_NORMAL;
            ST_CHECKER: pat_sel = PAT_CHECKER;
            ST_INVERSE: pat_sel = PAT_INVERSE;
        endcase
    end

    // host-visible storage; end state committed on the final test edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CHARS; i++) char_q[i] <= BLANK_CODE;
            flash_q <= '0;
            udc_q   <= '0;
            ctrl_q  <= '0;
        end else if (finish) begin
            for (int i = 0; i < N_CHARS; i++) char_q[i] <= BLANK_CODE;
            flash_q <= '0;
            udc_q   <= '1;
            ctrl_q  <= 8'((sum == GOLDEN_SUM) ? 1 : 0) << CW_PASS;
        end else if (wr_ok) begin
            for (int i = 0; i < N_CHARS; i++)
                if (host_addr == HADR_W'(i)) char_q[i] <= host_wdata;
            if (host_addr == FLASH_ADR) flash_q <= host_wdata[N_CHARS-1:0];
            if (host_addr == UDC_ADR)   udc_q   <= host_wdata[UDC_AW-1:0];
            if (host_addr == CTRL_ADR)
                ctrl_q <= {host_wdata[7:6], ctrl_q[CW_PASS], host_wdata[4:0]};
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < N_CHARS; i++)
            if (host_addr == HADR_W'(i)) host_rdata = char_q[i];
        if (host_addr == FLASH_ADR) host_rdata = 8'(flash_q);
        if (host_addr == UDC_ADR)   host_rdata = 8'(udc_q);
        if (host_addr == CTRL_ADR)  host_rdata = ctrl_q;
    end
endmodule

// File: rtl/dst_selftest_chk.sv
module dst_selftest_chk #(
    parameter int TEST_LOG2 = 18,
    parameter int ROM_AW    = 7,
    parameter int N_CHARS   = 8,
    parameter int UDC_AW    = 4,
    parameter int HADR_W    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_we,
    input logic [HADR_W-1:0]       host_addr,
    input logic [7:0]              host_wdata,
    input logic                    busy,
    input logic [ROM_AW-1:0]       rom_addr,
    input logic [1:0]              pat_sel,
    input logic [N_CHARS-1:0][7:0] char_q,
    input logic [N_CHARS-1:0]      flash_q,
    input logic [UDC_AW-1:0]       udc_q,
    input logic [7:0]              ctrl_q
);
    localparam longint unsigned TOTAL = 64'd1 << TEST_LOG2;
    localparam longint unsigned EIGHT = TOTAL >> 3;
    localparam logic [TEST_LOG2:0] T_LEN   = (TEST_LOG2+1)'(TOTAL);
    localparam logic [TEST_LOG2:0] Q_END   = (TEST_LOG2+1)'(2 * EIGHT);
    localparam logic [TEST_LOG2:0] C_END   = (TEST_LOG2+1)'(5 * EIGHT);
    localparam logic [TEST_LOG2:0] R_DEPTH = (TEST_LOG2+1)'(64'd1 << ROM_AW);
    localparam logic [HADR_W-1:0]  CTRL_A  = HADR_W'(N_CHARS + 2);

    logic [TEST_LOG2:0] bcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !busy && host_addr == CTRL_A && host_wdata[6]) |=> busy);
    p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == T_LEN));
    p_bit6_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctrl_q[6]);
    p_rom_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt < R_DEPTH) |-> (rom_addr == bcnt[ROM_AW-1:0]));
    p_pat_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt < Q_END) |-> (pat_sel == 2'd0));
    p_pat_chk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt >= Q_END && bcnt < C_END) |-> (pat_sel == 2'd1));
    p_pat_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt >= C_END) |-> (pat_sel == 2'd2));
    p_pat_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pat_sel == 2'd0));
    p_pass_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ctrl_q[5]));
    p_end_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!ctrl_q[6] && !ctrl_q[7] && (&udc_q) && flash_q == '0));
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(char_q) && $stable(flash_q) && $stable(udc_q)));
endmodule

bind disp_selftest dst_selftest_chk #(
    .TEST_LOG2 (TEST_LOG2),
    .ROM_AW    (ROM_AW),
    .N_CHARS   (N_CHARS),
    .UDC_AW    (UDC_AW),
    .HADR_W    (HADR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .rom_addr   (rom_addr),
    .pat_sel    (pat_sel),
    .char_q     (char_q),
    .flash_q    (flash_q),
    .udc_q      (udc_q),
    .ctrl_q     (ctrl_q)
);

// File: tb/disp_selftest_test.sv
module disp_selftest_test;
    localparam int TL    = 10;
    localparam int RAW   = 7;
    localparam int NCH   = 8;
    localparam int UAW   = 4;
    localparam int HAW   = 4;
    localparam int TOTAL = 1 << TL;
    localparam int QLEN  = TOTAL / 4;
    localparam int PLEN  = 3 * TOTAL / 8;
    localparam int DEPTH = 1 << RAW;
    localparam logic [HAW-1:0] FL_A = HAW'(NCH);
    localparam logic [HAW-1:0] UD_A = HAW'(NCH + 1);
    localparam logic [HAW-1:0] CW_A = HAW'(NCH + 2);

    function automatic logic [7:0] rom_fn(input int a);
        logic [7:0] v;
        v = 8'(a * 37 + 11);
        return v ^ 8'(a >> 2);
    endfunction

    function automatic logic [7:0] rom_total();
        logic [7:0] s = 8'h00;
        for (int a = 0; a < DEPTH; a++) s = s + rom_fn(a);
        return s;
    endfunction

    localparam logic [7:0] GOLD = rom_total();

    function automatic logic [1:0] exp_pat(input int k);
        if (k < QLEN) return 2'd0;
        if (k < QLEN + PLEN) return 2'd1;
        return 2'd2;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [HAW-1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic busy;
    logic [RAW-1:0] rom_addr;
    logic [7:0] rom_data;
    logic [1:0] pat_sel;
    logic corrupt = 1'b0;
    logic [RAW-1:0] bad_addr = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    assign rom_data = rom_fn(int'(rom_addr)) ^ ((corrupt && rom_addr == bad_addr) ? 8'h01 : 8'h00);

    disp_selftest #(
        .TEST_LOG2 (TL), .ROM_AW (RAW), .N_CHARS (NCH), .UDC_AW (UAW),
        .HADR_W (HAW), .GOLDEN_SUM (GOLD)
    ) uut (
        .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata), .busy (busy),
        .rom_addr (rom_addr), .rom_data (rom_data), .pat_sel (pat_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [HAW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [HAW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    logic exp_pass = 1'b0;

    task automatic run_test(input bit bad, input logic [RAW-1:0] where);
        logic [7:0] v, c3, wv;
        int k, rom_bad, pat_bad;
        corrupt = bad; bad_addr = where;
        // R2: idle writes land, bit 5 is read-only
        c3 = 8'($urandom);
        wr(3, c3); rd(3, v);
        check(v == c3, "R2 char write", v, c3);
        wv = 8'($urandom) & 8'hBF;
        wr(CW_A, wv); rd(CW_A, v);
        check(v == {wv[7:6], exp_pass, wv[4:0]}, "R2 ctrl bit5 read-only", v, {wv[7:6], exp_pass, wv[4:0]});
        wv = 8'($urandom); wr(FL_A, wv); rd(FL_A, v);
        check(v == wv, "R2 flash write", v, wv);
        wv = 8'($urandom); wr(UD_A, wv); rd(UD_A, v);
        check(v == {4'h0, wv[3:0]}, "R2 udc write", v, {4'h0, wv[3:0]});
        // R3: start
        wr(CW_A, 8'($urandom) | 8'h40);
        k = 0; rom_bad = 0; pat_bad = 0;
        while (busy && k < 2 * TOTAL) begin
            if (k < DEPTH && int'(rom_addr) != k) rom_bad++;
            if (pat_sel != exp_pat(k)) pat_bad++;
            host_we = 1'b0;
            if (k == 40) begin host_we = 1'b1; host_addr = 3; host_wdata = ~c3; end
            if (k == 41) host_addr = 3;
            if (k == 42) check(host_rdata == c3, "R8 write ignored while busy", host_rdata, c3);
            if (k == 43) host_addr = CW_A;
            if (k == 44) check(host_rdata[6] == 1'b1, "R3 bit6 reads 1 while busy", host_rdata, 8'h40);
            if (k == 60) begin host_we = 1'b1; host_addr = CW_A; host_wdata = 8'h40; end
            @(negedge clk);
            k++;
        end
        host_we = 1'b0;
        check(k == TOTAL, "R3/R8 busy length", k, TOTAL);
        check(rom_bad == 0, "R4 rom address walk", rom_bad, 0);
        check(pat_bad == 0, "R5 pattern schedule", pat_bad, 0);
        check(pat_sel == 2'd0, "R5 idle pattern", pat_sel, 0);
        exp_pass = !bad;
        rd(CW_A, v);
        check(v == {2'b00, exp_pass, 5'b0}, "R6/R7 control end state", v, {2'b00, exp_pass, 5'b0});
        for (int i = 0; i < NCH; i++) begin
            rd(HAW'(i), v);
            check(v == 8'h20, "R7 char blank", v, 8'h20);
        end
        rd(FL_A, v); check(v == 8'h00, "R7 flash clear", v, 0);
        rd(UD_A, v); check(v == 8'h0F, "R7 udc all ones", v, 8'h0F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < NCH; i++) begin
            rd(HAW'(i), v);
            check(v == 8'h20, "R1 char reset", v, 8'h20);
        end
        rd(FL_A, v); check(v == 0, "R1 flash reset", v, 0);
        rd(UD_A, v); check(v == 0, "R1 udc reset", v, 0);
        rd(CW_A, v); check(v == 0, "R1 ctrl reset", v, 0);
        check(busy == 1'b0 && pat_sel == 2'd0, "R1 outputs idle", {busy, pat_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(CW_A, v); check(v == 0, "R1 ctrl after release", v, 0);
        run_test(1'b0, '0);
        run_test(1'b1, '0);
        run_test(1'b0, '0);
        run_test(1'b1, RAW'(DEPTH - 1));
        for (int r = 0; r < 4; r++) run_test(1'($urandom), RAW'($urandom));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule